// File: doc/BRIEF.md
# Supply-Voltage Monitor Controller

This block is the digital side of a supply-voltage guard. An analog front end provides two comparator flags. One says the supply has fallen below a lower trip level. The other says it has risen above a higher trip level. The gap between the two levels gives the block its hysteresis. Both flags are asynchronous, so the block first synchronises them. It then runs a two-state machine that remembers a low-supply event until the supply has clearly recovered.

Two configuration bits, held in registers elsewhere, choose the mode of operation:
- A power-down bit switches the whole function off.
- A reset-off bit keeps the block in polled mode. In this mode software watches a status flag, and no reset is requested.

With both bits clear, a low-supply event raises a reset request to the system reset logic. That request stays up across any chatter near the lower level. Only the higher comparator flag releases it. The status flag can also be read over a byte-wide register bus at one fixed address.

Top module: `supply_monitor`

## Requirements
- R1: After a synchronous reset, `low_flag` and `reset_req` are 0, and a read of the status address returns 0x00.
- R2: A read strobe at the status address (default 0x0C) returns the flag in bit 7, with bits 6..0 always 0. The data appears on `bus_rdata` one clock after the strobe. If there is no strobe, or the address does not match, `bus_rdata` is 0x00 on the next clock.
- R3: Bus writes to any address, including the status address, have no effect on `low_flag`, `reset_req` or the read data.
- R4: While `cfg_pwr_down` is 1, `low_flag` and `reset_req` are 0 from the next clock edge on, whatever the comparator inputs do. The machine returns to its normal state.
- R5: In polled mode (`cfg_pwr_down`=0, `cfg_rst_off`=1), a low-supply flag sets `low_flag`, and `reset_req` stays 0.
- R6: In forced-reset mode (both configuration bits 0), a low-supply flag sets both `low_flag` and `reset_req`.
- R7: Once tripped, the block keeps `low_flag`, and `reset_req` in forced-reset mode, asserted while the above-rise flag is 0. This holds however the below-fall flag toggles.
- R8: Once the above-rise flag is 1, a tripped block clears `low_flag` and `reset_req`.
- R9: A change on a comparator input reaches `low_flag` and `reset_req` on the third rising clock edge after it. The path is two synchroniser stages plus the state register.
- R10: If `cfg_rst_off` is set while tripped, `reset_req` drops at the next edge and `low_flag` stays 1. Clearing `cfg_rst_off` again restores `reset_req` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_below_fall | input | 1 | Asynchronous flag: supply below the falling trip level |
| cmp_above_rise | input | 1 | Asynchronous flag: supply above the rising trip level |
| cfg_pwr_down | input | 1 | 1 switches the monitor off |
| cfg_rst_off | input | 1 | 1 suppresses the reset request (polled mode) |
| bus_addr | input | 8 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (ignored) |
| bus_wdata | input | 8 | Write data (ignored) |
| bus_rdata | output | 8 | Registered read data |
| low_flag | output | 1 | Low-supply status flag |
| reset_req | output | 1 | Reset request to the system reset logic |

## Verification
The assertions assume the two comparator flags are never high together. A physical supply cannot be below the lower level and above the higher level at the same time. They also assume the configuration bits are synchronous to `clk`.

The stimulus respects both assumptions. Every ramp lowers the above-rise flag before raising the below-fall flag, and the reverse on the way up. Chatter toggles only the below-fall flag while the above-rise flag is held at 0. Configuration changes are driven on the falling clock edge.

// File: rtl/supmon_pkg.sv
// Shared types for the supply monitor.
package supmon_pkg;

    // Trip state of the hysteresis machine.
    typedef enum logic {
        ST_NORMAL      = 1'b0,
        ST_LOW_TRIPPED = 1'b1
    } trip_state_e;

endpackage

// File: rtl/supmon_sync.sv
// Multi-stage synchroniser for a vector of independent asynchronous flags.
// Assumes each bit is a level that is stable for several clocks, so the
// bits need no mutual coherence. Every stage clears on synchronous reset.
module supmon_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_in;
            end
        end else begin : g_next
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/supmon_fsm.sv
// Hysteresis state machine for the supply monitor.
// Enters the tripped state on the synchronised below-fall flag. Leaves it
// only on the synchronised above-rise flag, or when the module is powered
// down. The reset request is registered together with the state.
// Assumes the two flags are never high together and the configuration bits
// are synchronous to clk.
module supmon_fsm
    import supmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below_s,
    input  logic above_s,
    input  logic pwr_down,
    input  logic rst_off,
    output logic low_flag,
    output logic reset_req
);

    trip_state_e state_q, state_d;
    logic        req_q;

    // Next-state selection: power-down wins, then trip or release.
    always_comb begin
        state_d = state_q;
        if (pwr_down) begin
            state_d = ST_NORMAL;
        end else begin
            case (state_q)
                ST_NORMAL:      if (below_s) state_d = ST_LOW_TRIPPED;
                ST_LOW_TRIPPED: if (above_s) state_d = ST_NORMAL;
                default:        state_d = ST_NORMAL;
            endcase
        end
    end

    // State and reset-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= (state_d == ST_LOW_TRIPPED) && !rst_off;
        end
    end

    assign low_flag  = (state_q == ST_LOW_TRIPPED);
    assign reset_req = req_q;

    // R4: power-down clears both outputs at the next edge.
    a_r4_pwrdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!low_flag && !reset_req));

    // R5: polled mode never requests reset.
    a_r5_polled_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_off |=> !reset_req);

    // R6: a low-supply flag in forced-reset mode raises the request.
    a_r6_forced_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_flag && below_s && !pwr_down && !rst_off) |=> (reset_req && low_flag));

    // R7: hold while no rising-threshold flag is present.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (low_flag && !above_s && !pwr_down) |=> low_flag);

    // R8: the rising-threshold flag releases the trip.
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (low_flag && above_s) |=> (!low_flag && !reset_req));

    // R10: a reset request only exists while tripped.
    a_r10_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> low_flag);

endmodule

// File: rtl/supmon_regif.sv
// Byte-wide read-only status register.
// A read strobe at STATUS_ADDR returns the flag in the top bit and zeros
// below it, registered one clock after the strobe. Any other cycle returns
// zero. Writes are accepted on the bus and discarded.
module supmon_regif #(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - 1;

    logic              hit;
    logic [DATA_W:0]   wr_unused;
    logic [DATA_W-1:0] rdata_q;

    assign hit       = bus_rd && (bus_addr == STATUS_ADDR);
    assign wr_unused = {bus_wr, bus_wdata};

    // Read data register: flag on a hit, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   rdata_q <= '0;
        else if (hit) rdata_q <= {flag, {PAD_W{1'b0}}};
        else          rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

    // R2: no hit means a zero bus on the next cycle.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (bus_rdata == '0));

    // R2: a hit returns the flag in the top bit with zero padding.
    a_r2_flag_bit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (bus_rdata == {$past(flag), {PAD_W{1'b0}}}));

endmodule

// File: rtl/supply_monitor.sv
// Top of the supply-voltage monitor controller.
// Synchronises the two comparator flags, runs the hysteresis machine and
// exposes the status flag on a byte-wide register bus.
// Assumes the configuration bits come from registers clocked by clk.
module supply_monitor #(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_below_fall,
    input  logic              cmp_above_rise,
    input  logic              cfg_pwr_down,
    input  logic              cfg_rst_off,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              low_flag,
    output logic              reset_req
);

    localparam int N_CMP = 2;

    logic [N_CMP-1:0] cmp_raw;
    logic [N_CMP-1:0] cmp_s;
    logic             flag_w;

    assign cmp_raw = {cmp_above_rise, cmp_below_fall};

    supmon_sync #(
        .WIDTH  (N_CMP),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_raw),
        .sync_out (cmp_s)
    );

    supmon_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .below_s   (cmp_s[0]),
        .above_s   (cmp_s[1]),
        .pwr_down  (cfg_pwr_down),
        .rst_off   (cfg_rst_off),
        .low_flag  (flag_w),
        .reset_req (reset_req)
    );

    supmon_regif #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .flag      (flag_w),
        .bus_rdata (bus_rdata)
    );

    assign low_flag = flag_w;

endmodule

// File: tb/tb_supply_monitor.sv
// Self-checking bench for supply_monitor: ramps, chatter, mode sweep.
module tb_supply_monitor;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       below, above, pd, roff;
    logic [7:0] addr, wdata;
    logic       rd, wr;
    logic [7:0] rdata;
    logic       flag, rreq;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [7:0] ST_ADDR = 8'h0C;

    always #10 clk = ~clk;

    supply_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .cmp_below_fall(below), .cmp_above_rise(above),
        .cfg_pwr_down(pd), .cfg_rst_off(roff),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .low_flag(flag), .reset_req(rreq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        tick(1);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick(1);
        wr = 1'b0;
    endtask

    // Raise the supply back above the rising level, then return between levels.
    task automatic recover();
        below = 1'b0; above = 1'b1;
        tick(4);
        above = 1'b0;
        tick(3);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] d;
        rst_n = 1'b0; below = 0; above = 0; pd = 0; roff = 0;
        addr = 0; wdata = 0; rd = 0; wr = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        chk("R1 flag", {7'b0, flag}, 8'h00);
        chk("R1 reset_req", {7'b0, rreq}, 8'h00);
        bus_read(ST_ADDR, d);
        chk("R1 read", d, 8'h00);

        // R9 and R6: trip in forced mode, third edge latency
        below = 1'b1;
        tick(2);
        chk("R9 flag before 3rd edge", {7'b0, flag}, 8'h00);
        tick(1);
        chk("R9 flag at 3rd edge", {7'b0, flag}, 8'h01);
        chk("R6 reset_req forced", {7'b0, rreq}, 8'h01);

        // R2: read decoding
        bus_read(ST_ADDR, d);
        chk("R2 status read", d, 8'h80);
        bus_read(8'h0D, d);
        chk("R2 other address", d, 8'h00);
        tick(1);
        chk("R2 idle bus", rdata, 8'h00);

        // R3: writes are ignored
        bus_write(ST_ADDR, 8'h00);
        bus_write(ST_ADDR, 8'h7F);
        bus_write(8'h0D, 8'h00);
        tick(2);
        chk("R3 flag after writes", {7'b0, flag}, 8'h01);
        chk("R3 reset_req after writes", {7'b0, rreq}, 8'h01);
        bus_read(ST_ADDR, d);
        chk("R3 read after writes", d, 8'h80);

        // R7: chatter near the falling level, then hover between levels
        for (int i = 0; i < 60; i++) begin
            below = (i % 3) != 0;
            tick(1);
            chk("R7 chatter reset held", {7'b0, rreq}, 8'h01);
        end
        below = 1'b0;
        tick(10);
        chk("R7 hover flag held", {7'b0, flag}, 8'h01);
        chk("R7 hover reset held", {7'b0, rreq}, 8'h01);

        // R8: release only on the rising-level flag
        above = 1'b1;
        tick(2);
        chk("R8 still held before sync", {7'b0, rreq}, 8'h01);
        tick(1);
        chk("R8 flag released", {7'b0, flag}, 8'h00);
        chk("R8 reset released", {7'b0, rreq}, 8'h00);
        above = 1'b0;
        tick(3);

        // R10: reset-off toggled while tripped
        below = 1'b1;
        tick(3);
        roff = 1'b1;
        tick(1);
        chk("R10 reset dropped", {7'b0, rreq}, 8'h00);
        chk("R10 flag kept", {7'b0, flag}, 8'h01);
        roff = 1'b0;
        tick(1);
        chk("R10 reset restored", {7'b0, rreq}, 8'h01);

        // R4: power-down while tripped and with the input active
        pd = 1'b1;
        tick(1);
        chk("R4 flag cleared", {7'b0, flag}, 8'h00);
        chk("R4 reset cleared", {7'b0, rreq}, 8'h00);
        for (int i = 0; i < 12; i++) begin
            below = i[0];
            tick(1);
            chk("R4 ignored input", {6'b0, flag, rreq}, 8'h00);
        end
        below = 1'b1;
        tick(3);
        bus_read(ST_ADDR, d);
        chk("R4 read while off", d, 8'h00);
        pd = 1'b0;
        tick(1);
        chk("R4 re-enable trips", {6'b0, flag, rreq}, 8'h03);
        recover();

        // R5: polled mode
        roff = 1'b1;
        below = 1'b1;
        tick(3);
        chk("R5 polled flag", {7'b0, flag}, 8'h01);
        for (int i = 0; i < 20; i++) begin
            below = (i % 4) < 2;
            tick(1);
            chk("R5 polled no reset", {7'b0, rreq}, 8'h00);
        end
        chk("R5 polled flag held", {7'b0, flag}, 8'h01);
        recover();
        chk("R5 polled released", {7'b0, flag}, 8'h00);
        roff = 1'b0;

        // R4 R5 R6 R8: sweep of all configuration pairs
        for (int c = 0; c < 4; c++) begin
            logic epd, eoff;
            epd = c[1]; eoff = c[0];
            pd = epd; roff = eoff;
            tick(1);
            below = 1'b1;
            tick(4);
            chk("R6 sweep flag", {7'b0, flag}, {7'b0, !epd});
            chk("R6 sweep reset", {7'b0, rreq}, {7'b0, !epd && !eoff});
            recover();
            chk("R8 sweep released", {6'b0, flag, rreq}, 8'h00);
        end
        pd = 1'b0; roff = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule